// File: doc/BRIEF.md
# Interrupt Priority Claim Arbiter

This block picks, for a single interrupt target context, the source that should be handed out next. Each source has a pending bit, a claimed bit, an enable bit for this context and a 3-bit priority. The context has a 3-bit threshold. A source competes only if all of the following hold: it is pending, it is not claimed, it is enabled, and its priority is above the threshold. Among the competing sources the block reports the number of the winner. It also raises a request level whenever at least one source competes.

One instance is placed per context. The surrounding controller owns the register bus, the claim and complete side effects, and the routing of request levels to processor privilege levels. The block only evaluates the vectors it is given and registers the result. Source numbers run from 1 to `N_SRC`. Number 0 means "nothing to claim".

Top module: `prio_claim_arb`

## Requirements
- R1: A source n (1..N_SRC) is eligible only when its pending bit is 1, its claimed bit is 0 and its enable bit is 1. Clearing any one of these three conditions removes the source from selection.
- R2: An eligible source must also have a priority strictly greater than `thresh_i`. A priority equal to the threshold does not qualify.
- R3: `id_o` names a qualifying source with the largest priority among all qualifying sources.
- R4: When several qualifying sources share the largest priority, the lowest-numbered one is reported.
- R5: `id_o` is 0 when no source qualifies.
- R6: `irq_o` is 1 exactly when at least one source qualifies, and hence exactly when `id_o` is nonzero.
- R7: Source 0 is never selected, whatever its pending, enable and priority bits hold. `id_o` never exceeds `N_SRC`.
- R8: Both outputs are registered. They reflect the inputs sampled at the previous rising clock edge. While `rst_ni` is low, they read `irq_o`=0 and `id_o`=0.
- R9: Bit vectors are given as 32-bit words. Source n is at word n>>5, bit n&31. The priority of source n is element n of `prio_i`, where bit 0 of that element is the least significant bit.
- R10: A source with priority 0 never qualifies, for any threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NW x 32 | Pending bits, one per source, where NW = ceil((N_SRC+1)/32) |
| claim_i | input | NW x 32 | Claimed (in service) bits, one per source |
| en_i | input | NW x 32 | Enable bits of this context, one per source |
| prio_i | input | (N_SRC+1) x 3 | Priority of each source; element 0 is ignored |
| thresh_i | input | 3 | Context threshold |
| irq_o | output | 1 | Request level for the context |
| id_o | output | ceil(log2(N_SRC+1)) | Winning source number, 0 when none |

## Verification
The bound checker keeps a copy of the inputs from the previous clock edge. On every cycle it confirms the following about the reported source:
- It is pending, unclaimed, enabled and above the threshold.
- No qualifying source has a higher priority.
- No lower-numbered source ties with it.
- The request level agrees with a nonzero identifier.

Some behaviour only the bench scenarios can show:
- The output holds its old value until the clock edge after an input change.
- Source 0 stays silent even at top priority.
- Priority-0 sources and threshold-equal sources are excluded.

A long pseudo-random sweep of a seven-source configuration is compared against an arithmetic model.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;

  // right-hand candidate replaces left only when strictly better
  function automatic logic take_right(input logic l_vld, input prio_t l_pr,
                                      input logic r_vld, input prio_t r_pr);
    return r_vld && (!l_vld || (r_pr > l_pr));
  endfunction
endpackage

// File: rtl/prio_elig_mask.sv
module prio_elig_mask
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 31,
  localparam int NW = (N_SRC + 32) / 32
) (
  input  logic [NW-1:0][31:0] pend_i,
  input  logic [NW-1:0][31:0] claim_i,
  input  logic [NW-1:0][31:0] en_i,
  input  prio_t [N_SRC:0]     prio_i,
  input  prio_t               thresh_i,
  output logic [N_SRC:0]      elig_o
);
  localparam int PAD = NW * 32 - (N_SRC + 1);

  logic [NW*32-1:0] pend_f, claim_f, en_f;
  assign pend_f  = pend_i;
  assign claim_f = claim_i;
  assign en_f    = en_i;

  // source 0 is reserved
  assign elig_o[0] = 1'b0;

  for (genvar n = 1; n <= N_SRC; n++) begin : src_g
    assign elig_o[n] = pend_f[n] & ~claim_f[n] & en_f[n] & (prio_i[n] > thresh_i);
  end

  logic unused_src0;
  assign unused_src0 = pend_f[0] ^ claim_f[0] ^ en_f[0];

  if (PAD > 0) begin : pad_g
    logic unused_pad;
    assign unused_pad = ^{pend_f[NW*32-1:N_SRC+1], claim_f[NW*32-1:N_SRC+1],
                          en_f[NW*32-1:N_SRC+1]};
  end
endmodule

// File: rtl/prio_max_tree.sv
module prio_max_tree
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 31,
  localparam int IDW    = $clog2(N_SRC + 1),
  localparam int LEAVES = 1 << IDW
) (
  input  logic [N_SRC:0]  elig_i,
  input  prio_t [N_SRC:0] prio_i,
  output logic            win_vld_o,
  output logic [IDW-1:0]  win_id_o
);
  // lower-numbered sources always sit in the left subtree
  for (genvar l = 0; l <= IDW; l++) begin : lvl_g
    localparam int W = LEAVES >> l;
    logic  [W-1:0]          vld;
    prio_t [W-1:0]          pr;
    logic  [W-1:0][IDW-1:0] id;

    if (l == 0) begin : leaf_g
      for (genvar k = 0; k < W; k++) begin : k_g
        if (k <= N_SRC) begin : real_g
          assign vld[k] = elig_i[k];
          assign pr[k]  = prio_i[k];
        end else begin : pad_g
          assign vld[k] = 1'b0;
          assign pr[k]  = '0;
        end
        assign id[k] = IDW'(k);
      end
    end else begin : node_g
      for (genvar k = 0; k < W; k++) begin : k_g
        logic pick_r;
        assign pick_r = take_right(lvl_g[l-1].vld[2*k],   lvl_g[l-1].pr[2*k],
                                   lvl_g[l-1].vld[2*k+1], lvl_g[l-1].pr[2*k+1]);
        assign vld[k] = lvl_g[l-1].vld[2*k] | lvl_g[l-1].vld[2*k+1];
        assign pr[k]  = pick_r ? lvl_g[l-1].pr[2*k+1] : lvl_g[l-1].pr[2*k];
        assign id[k]  = pick_r ? lvl_g[l-1].id[2*k+1] : lvl_g[l-1].id[2*k];
      end
    end
  end

  logic unused_root_pr;
  assign unused_root_pr = ^lvl_g[IDW].pr[0];

  assign win_vld_o = lvl_g[IDW].vld[0];
  assign win_id_o  = lvl_g[IDW].id[0];
endmodule

// File: rtl/prio_out_reg.sv
module prio_out_reg #(
  parameter int IDW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic [IDW-1:0] id_i,
  output logic           irq_o,
  output logic [IDW-1:0] id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      id_o  <= '0;
    end else begin
      irq_o <= vld_i;
      id_o  <= vld_i ? id_i : '0;
    end
  end
endmodule

// File: rtl/prio_claim_arb.sv
module prio_claim_arb
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 31,
  localparam int NW  = (N_SRC + 32) / 32,
  localparam int IDW = $clog2(N_SRC + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NW-1:0][31:0]    pend_i,
  input  logic [NW-1:0][31:0]    claim_i,
  input  logic [NW-1:0][31:0]    en_i,
  input  logic [N_SRC:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]      thresh_i,
  output logic                   irq_o,
  output logic [IDW-1:0]         id_o
);
  logic [N_SRC:0] elig;
  logic           win_vld;
  logic [IDW-1:0] win_id;

  prio_elig_mask #(.N_SRC(N_SRC)) u_mask (
    .pend_i  (pend_i),
    .claim_i (claim_i),
    .en_i    (en_i),
    .prio_i  (prio_i),
    .thresh_i(thresh_i),
    .elig_o  (elig)
  );

  prio_max_tree #(.N_SRC(N_SRC)) u_tree (
    .elig_i   (elig),
    .prio_i   (prio_i),
    .win_vld_o(win_vld),
    .win_id_o (win_id)
  );

  prio_out_reg #(.IDW(IDW)) u_oreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (win_vld),
    .id_i  (win_id),
    .irq_o (irq_o),
    .id_o  (id_o)
  );
endmodule

// File: rtl/prio_claim_arb_chk.sv
module prio_claim_arb_chk
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 31,
  localparam int NW  = (N_SRC + 32) / 32,
  localparam int IDW = $clog2(N_SRC + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NW-1:0][31:0]    pend_i,
  input logic [NW-1:0][31:0]    claim_i,
  input logic [NW-1:0][31:0]    en_i,
  input logic [N_SRC:0][PRIO_W-1:0] prio_i,
  input logic [PRIO_W-1:0]      thresh_i,
  input logic                   irq_o,
  input logic [IDW-1:0]         id_o
);
  logic [NW*32-1:0] pend_q, claim_q, en_q;
  logic [N_SRC:0][PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0; claim_q <= '0; en_q <= '0; prio_q <= '0; thr_q <= '0;
    end else begin
      pend_q <= pend_i; claim_q <= claim_i; en_q <= en_i;
      prio_q <= prio_i; thr_q <= thresh_i;
    end
  end

  logic any_q, sel_ok, higher, tie_lower;
  logic [PRIO_W-1:0] sel_pr;

  always_comb begin
    any_q = 1'b0; sel_ok = 1'b0; higher = 1'b0; tie_lower = 1'b0; sel_pr = '0;
    for (int k = 1; k <= N_SRC; k++) begin
      if (k == int'(id_o)) begin
        sel_pr = prio_q[k];
        sel_ok = pend_q[k] && !claim_q[k] && en_q[k] && (prio_q[k] > thr_q);
      end
    end
    for (int k = 1; k <= N_SRC; k++) begin
      if (pend_q[k] && !claim_q[k] && en_q[k] && (prio_q[k] > thr_q)) begin
        any_q = 1'b1;
        if (prio_q[k] > sel_pr) higher = 1'b1;
        if (prio_q[k] == sel_pr && k < int'(id_o)) tie_lower = 1'b1;
      end
    end
  end

  // R6
  irq_matches_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (id_o != '0));
  // R7
  id_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(id_o) <= N_SRC);
  // R1 R2
  sel_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sel_ok);
  // R3
  no_higher_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !higher);
  // R4
  tie_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !tie_lower);
  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_q |-> (id_o == '0));
  // R6
  req_when_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_q |-> irq_o);
endmodule

bind prio_claim_arb prio_claim_arb_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/sim_prio_claim_arb.sv
`timescale 1ns/1ps
module sim_prio_claim_arb;
  localparam int N   = 7;
  localparam int NW  = 1;
  localparam int IDW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NW-1:0][31:0] pend_i = '0, claim_i = '0, en_i = '0;
  logic [N:0][2:0] prio_i = '0;
  logic [2:0] thresh_i = '0;
  logic irq_o;
  logic [IDW-1:0] id_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk_i = ~clk_i;

  prio_claim_arb #(.N_SRC(N)) u0 (.*);

  function automatic int model_id();
    int best = 0;
    int bp = -1;
    for (int k = 1; k <= N; k++) begin
      if (pend_i[k>>5][k&31] && !claim_i[k>>5][k&31] && en_i[k>>5][k&31]
          && prio_i[k] > thresh_i && int'(prio_i[k]) > bp) begin
        best = k; bp = int'(prio_i[k]);
      end
    end
    return best;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int exp_id);
    chk(req, int'(id_o), exp_id);
    chk(req, int'(irq_o), (exp_id != 0) ? 1 : 0);
  endtask

  // drive at negedge, sample one ns after the next posedge
  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic clear();
    @(negedge clk_i);
    pend_i = '0; claim_i = '0; en_i = '0; prio_i = '0; thresh_i = '0;
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  initial begin
    // R8 reset state with eligible sources present
    pend_i[0] = 8'hFE; en_i[0] = 8'hFE;
    for (int k = 0; k <= N; k++) prio_i[k] = 3'd5;
    repeat (3) @(posedge clk_i);
    #1 chk_out("R8", 0);
    @(negedge clk_i) rst_ni = 1'b1;
    step();
    chk_out("R4", 1);

    // R1 claimed top source is skipped
    clear();
    pend_i[0] = 8'b0000_1100; en_i[0] = 8'b0000_1100; claim_i[0] = 8'b0000_1000;
    prio_i[3] = 3'd7; prio_i[2] = 3'd1;
    step(); chk_out("R1", 2);
    @(negedge clk_i) en_i[0][2] = 1'b0;
    step(); chk_out("R1", 0);
    @(negedge clk_i) begin en_i[0][2] = 1'b1; pend_i[0][2] = 1'b0; end
    step(); chk_out("R1", 0);
    @(negedge clk_i) claim_i[0][3] = 1'b0;
    step(); chk_out("R1", 3);

    // R2 strict threshold
    clear();
    pend_i[0][4] = 1'b1; en_i[0][4] = 1'b1; prio_i[4] = 3'd3; thresh_i = 3'd3;
    step(); chk_out("R2", 0);
    @(negedge clk_i) thresh_i = 3'd2;
    step(); chk_out("R2", 4);

    // R3 highest wins regardless of position
    clear();
    pend_i[0] = 8'hFE; en_i[0] = 8'hFE;
    for (int k = 1; k <= N; k++) prio_i[k] = 3'(k % 4);
    prio_i[6] = 3'd6;
    step(); chk_out("R3", 6);

    // R4 tie resolves to lowest number
    clear();
    pend_i[0] = 8'b0110_0100; en_i[0] = 8'hFF;
    prio_i[2] = 3'd4; prio_i[5] = 3'd4; prio_i[6] = 3'd4;
    step(); chk_out("R4", 2);

    // R7 source 0 at top priority is ignored
    clear();
    pend_i[0][0] = 1'b1; en_i[0][0] = 1'b1; prio_i[0] = 3'd7;
    step(); chk_out("R7", 0);

    // R10 priority zero never qualifies
    clear();
    pend_i[0] = 8'hFF; en_i[0] = 8'hFF;
    step(); chk_out("R10", 0);

    // R9 highest source at bit 7, priority in element 7
    clear();
    pend_i[0][7] = 1'b1; en_i[0][7] = 1'b1; prio_i[7] = 3'd1;
    step(); chk_out("R9", 7);

    // R8 one-cycle latency: output holds until next edge
    clear();
    pend_i[0] = 8'b0010_0100; en_i[0] = 8'hFF; prio_i[2] = 3'd3; prio_i[5] = 3'd1;
    step(); chk_out("R8", 2);
    @(negedge clk_i) prio_i[5] = 3'd6;
    #1 chk_out("R8", 2);
    step(); chk_out("R8", 5);

    // R5 nothing pending
    clear();
    step(); chk_out("R5", 0);

    // R3 R6 pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b, c;
      int exp_id;
      @(negedge clk_i);
      a = rnd(); b = rnd(); c = rnd();
      pend_i[0]  = {24'd0, a[7:0]};
      claim_i[0] = {24'd0, a[15:8] & a[23:16]};
      en_i[0]    = {24'd0, b[7:0] | b[15:8]};
      for (int k = 0; k <= N; k++) prio_i[k] = c[3*k +: 3];
      thresh_i = (i % 8 < 4) ? 3'd0 : b[18:16];
      exp_id = model_id();
      step();
      chk_out("R3", exp_id);
      chk("R6", int'(irq_o), (exp_id != 0) ? 1 : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule